// File: doc/BRIEF.md
# ADC Serial Command and Readout Front End

This block is the device-side digital serial port of a multichannel successive-approximation converter. A host selects the device with an active-low chip select and runs a serial clock. Each frame does two jobs at once. On the rising clock edges the host shifts in an 8-bit word, MSB first: a 4-bit channel or command code and four configuration bits. On the falling clock edges the device shifts out the result of the previous conversion. The serial output is three-state. Here that takes the form of a data bit plus an output-enable.

Chip select and the serial clock are synchronised into the system clock domain and edge-detected there. The serial clock may run at no more than a quarter of the system clock rate. When a complete frame of 16 serial clocks has been received, the new command and configuration take effect. A conversion then starts. The conversion is a stub with a fixed latency that captures a 12-bit test input. A status output can be programmed to work in one of two ways. As an interrupt, it is cleared by the serial clock. As an end-of-conversion flag, it marks the time the converter is busy.

Top module: `adc_serial_frontend`

## Requirements
- R1: After reset, `sdo_oe` is 0, `stat_n` is 1, `cmd` is 0, `cfg` is 0 and the stored result is 0.
- R2: While `cs_n` is high, `sdo_oe` is 0, and activity on `sclk` and `sdi` changes neither `cmd` nor `cfg`.
- R3: Every reaction to `cs_n`, `sclk` or `sdi` becomes visible 3 system clocks after the input change is registered. A falling `cs_n` sets `sdo_oe`, clears the bit counters and presents the first bit of the stored result on `sdo`.
- R4: The first 8 rising `sclk` edges of a frame sample `sdi`, MSB first. Bits 7:4 of the word become `cmd` and bits 3:0 become `cfg`, both at the 16th falling edge.
- R5: Each falling `sclk` edge moves `sdo` to the next result bit. The 12 result bits are followed by zeros up to the 16th clock.
- R6: With `cfg[1]`=0 the result leaves MSB first, and with `cfg[1]`=1 it leaves LSB first. The order in force when a frame begins applies to that frame.
- R7: The 16th falling edge starts a conversion that captures `conv_value`. The captured value becomes the stored result CONV_CYC system clocks later. Further `sclk` edges in the same selection are ignored.
- R8: If `cs_n` rises before the 16th falling edge, no conversion starts and `cmd` and `cfg` keep their previous values.
- R9: With `cfg[0]`=0 (interrupt mode), `stat_n` goes low in the cycle a conversion result is stored. It returns high on the next rising `sclk` edge seen while `cs_n` is low.
- R10: With `cfg[0]`=1 (end-of-conversion mode), `stat_n` goes low at the 16th falling edge. It returns high in the cycle the result is stored.
- R11: If a falling `cs_n` takes effect in the same cycle that a result is stored, the new result is the one shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous, idle low |
| sdi | input | 1 | Serial command/configuration data |
| conv_value | input | 12 | Test value captured by the conversion stub |
| sdo | output | 1 | Serial result bit, 0 when not enabled |
| sdo_oe | output | 1 | Output enable for the three-state result pin |
| stat_n | output | 1 | Interrupt or end-of-conversion status, active low |
| cmd | output | 4 | Channel/command code in force |
| cfg | output | 4 | Configuration bits in force |

## Verification
Two events can land in the same system-clock cycle: the conversion stub storing its result, and a falling chip select loading the output shift register. The bench ends a frame and then moves the next chip-select fall across four offsets that surround the conversion latency. The result before and the result after the conversion are chosen to differ in their first bit. The first bit driven must be the old one before the store cycle and the new one from the store cycle onward. A cycle-accurate behavioural model in the bench also checks every other output on every clock throughout the sweep.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
    // configuration bit positions decoded by the frame and status logic
    localparam int unsigned CFG_BIT_EOC       = 0;
    localparam int unsigned CFG_BIT_LSB_FIRST = 1;

    typedef enum logic {
        MODE_INT = 1'b0,
        MODE_EOC = 1'b1
    } stat_mode_e;
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_i;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.meta   <= RST_VAL;
            st_q.stable <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stable;
endmodule

// File: rtl/sfe_frame.sv
module sfe_frame
    import sfe_pkg::*;
#(
    parameter int unsigned RES_W      = 12,
    parameter int unsigned CMD_W      = 4,
    parameter int unsigned CFG_W      = 4,
    parameter int unsigned FRAME_CLKS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n_s,
    input  logic             sck_s,
    input  logic             sdi_s,
    input  logic [RES_W-1:0] res_i,
    input  logic [RES_W-1:0] res_next_i,
    input  logic             res_new_i,
    output logic             sdo_o,
    output logic             sdo_oe_o,
    output logic [CMD_W-1:0] cmd_o,
    output logic [CFG_W-1:0] cfg_o,
    output logic             start_o,
    output logic             start_eoc_o,
    output logic             sck_rise_sel_o
);
    localparam int unsigned IN_W  = CMD_W + CFG_W;
    localparam int unsigned CNT_W = $clog2(FRAME_CLKS + 1);

    typedef struct packed {
        logic             cs_p;
        logic             sck_p;
        logic             oe;
        logic             active;
        logic [CNT_W-1:0] falls;
        logic [IN_W-1:0]  in_sh;
        logic [RES_W-1:0] out_sh;
        logic [CMD_W-1:0] cmd;
        logic [CFG_W-1:0] cfg;
    } frame_st_t;

    frame_st_t st_d, st_q;

    logic             cs_fall, cs_rise, sck_rise, sck_fall;
    logic             start;
    logic [RES_W-1:0] res_src, res_rev, res_load;

    assign cs_fall  =  st_q.cs_p  & ~cs_n_s;
    assign cs_rise  = ~st_q.cs_p  &  cs_n_s;
    assign sck_rise = ~st_q.sck_p &  sck_s;
    assign sck_fall =  st_q.sck_p & ~sck_s;

    // a result stored in this very cycle is forwarded to the output loader
    assign res_src = res_new_i ? res_next_i : res_i;

    for (genvar b = 0; b < RES_W; b++) begin : g_rev
        assign res_rev[b] = res_src[RES_W-1-b];
    end

    assign res_load = st_q.cfg[CFG_BIT_LSB_FIRST] ? res_rev : res_src;

    always_comb begin
        st_d       = st_q;
        st_d.cs_p  = cs_n_s;
        st_d.sck_p = sck_s;
        start      = 1'b0;
        if (cs_fall) begin
            st_d.oe     = 1'b1;
            st_d.active = 1'b1;
            st_d.falls  = '0;
            st_d.in_sh  = '0;
            st_d.out_sh = res_load;
        end else if (cs_rise) begin
            st_d.oe     = 1'b0;
            st_d.active = 1'b0;
        end else if (st_q.active) begin
            if (sck_rise && (st_q.falls < CNT_W'(IN_W))) begin
                st_d.in_sh = {st_q.in_sh[IN_W-2:0], sdi_s};
            end
            if (sck_fall) begin
                st_d.out_sh = {st_q.out_sh[RES_W-2:0], 1'b0};
                st_d.falls  = st_q.falls + CNT_W'(1);
                if (st_q.falls == CNT_W'(FRAME_CLKS - 1)) begin
                    st_d.active = 1'b0;
                    st_d.cmd    = st_q.in_sh[IN_W-1 -: CMD_W];
                    st_d.cfg    = st_q.in_sh[CFG_W-1:0];
                    start       = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cs_p   <= 1'b1;
            st_q.sck_p  <= 1'b0;
            st_q.oe     <= 1'b0;
            st_q.active <= 1'b0;
            st_q.falls  <= '0;
            st_q.in_sh  <= '0;
            st_q.out_sh <= '0;
            st_q.cmd    <= '0;
            st_q.cfg    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo_o          = st_q.oe & st_q.out_sh[RES_W-1];
    assign sdo_oe_o       = st_q.oe;
    assign cmd_o          = st_q.cmd;
    assign cfg_o          = st_q.cfg;
    assign start_o        = start;
    assign start_eoc_o    = st_q.in_sh[CFG_BIT_EOC];
    assign sck_rise_sel_o = sck_rise & ~cs_n_s;

    AST_DESELECT_TRISTATES: assert property (@(posedge clk) disable iff (!rst_n) cs_rise |=> !sdo_oe_o); // R2
    AST_SELECT_DRIVES: assert property (@(posedge clk) disable iff (!rst_n) cs_fall |=> sdo_oe_o); // R3
    AST_FALLS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n) st_q.falls <= CNT_W'(FRAME_CLKS)); // R5
    AST_IDLE_KEEPS_CMD: assert property (@(posedge clk) disable iff (!rst_n) (!st_q.active && !cs_fall) |=> ($stable(cmd_o) && $stable(cfg_o))); // R7
    AST_ABORT_KEEPS_CMD: assert property (@(posedge clk) disable iff (!rst_n) (cs_rise && st_q.active) |=> ($stable(cmd_o) && $stable(cfg_o))); // R8
endmodule

// File: rtl/sfe_conv.sv
module sfe_conv #(
    parameter int unsigned RES_W    = 12,
    parameter int unsigned CONV_CYC = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [RES_W-1:0] value_i,
    output logic [RES_W-1:0] res_o,
    output logic [RES_W-1:0] res_next_o,
    output logic             done_o
);
    localparam int unsigned CW = $clog2(CONV_CYC + 1);

    typedef struct packed {
        logic             busy;
        logic [CW-1:0]    cnt;
        logic [RES_W-1:0] samp;
        logic [RES_W-1:0] res;
    } conv_st_t;

    conv_st_t st_d, st_q;
    logic     done;

    assign done = st_q.busy && (st_q.cnt == '0) && !start_i;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CW'(CONV_CYC - 1);
            st_d.samp = value_i;
        end else if (done) begin
            st_d.busy = 1'b0;
            st_d.res  = st_q.samp;
        end else if (st_q.busy) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy <= 1'b0;
            st_q.cnt  <= '0;
            st_q.samp <= '0;
            st_q.res  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o      = st_q.res;
    assign res_next_o = st_q.samp;
    assign done_o     = done;

    AST_START_MAKES_BUSY: assert property (@(posedge clk) disable iff (!rst_n) start_i |=> st_q.busy); // R7
    AST_SAMPLE_HELD: assert property (@(posedge clk) disable iff (!rst_n) (st_q.busy && !start_i) |=> $stable(st_q.samp)); // R7
endmodule

// File: rtl/sfe_status.sv
module sfe_status
    import sfe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic start_eoc_i,
    input  logic done_i,
    input  logic clr_i,
    output logic stat_n_o
);
    typedef struct packed {
        logic       stat;
        stat_mode_e mode;
    } status_st_t;

    status_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (done_i) begin
            st_d.stat = (st_q.mode == MODE_EOC);
        end else if (start_i) begin
            st_d.mode = start_eoc_i ? MODE_EOC : MODE_INT;
            if (start_eoc_i) begin
                st_d.stat = 1'b0;
            end
        end else if (clr_i && (st_q.mode == MODE_INT)) begin
            st_d.stat = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stat <= 1'b1;
            st_q.mode <= MODE_INT;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_n_o = st_q.stat;

    AST_INT_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n) (done_i && st_q.mode == MODE_INT) |=> !stat_n_o); // R9
    AST_EOC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (done_i && st_q.mode == MODE_EOC) |=> stat_n_o); // R10
    AST_EOC_BUSY_LOW: assert property (@(posedge clk) disable iff (!rst_n) (start_i && start_eoc_i) |=> !stat_n_o); // R10
endmodule

// File: rtl/adc_serial_frontend.sv
module adc_serial_frontend #(
    parameter int unsigned RES_W      = 12,
    parameter int unsigned CMD_W      = 4,
    parameter int unsigned CFG_W      = 4,
    parameter int unsigned FRAME_CLKS = 16,
    parameter int unsigned CONV_CYC   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             sdi,
    input  logic [RES_W-1:0] conv_value,
    output logic             sdo,
    output logic             sdo_oe,
    output logic             stat_n,
    output logic [CMD_W-1:0] cmd,
    output logic [CFG_W-1:0] cfg
);
    logic [2:0]       pins_s;
    logic             start, start_eoc, done, clr;
    logic [RES_W-1:0] res, res_next;

    // bit 0 chip select (idles high), bit 1 serial clock, bit 2 serial data
    sfe_sync #(.W(3), .RST_VAL(3'b001)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sdi, sclk, cs_n}),
        .sync_o  (pins_s)
    );

    sfe_frame #(
        .RES_W(RES_W), .CMD_W(CMD_W), .CFG_W(CFG_W), .FRAME_CLKS(FRAME_CLKS)
    ) u_frame (
        .clk            (clk),
        .rst_n          (rst_n),
        .cs_n_s         (pins_s[0]),
        .sck_s          (pins_s[1]),
        .sdi_s          (pins_s[2]),
        .res_i          (res),
        .res_next_i     (res_next),
        .res_new_i      (done),
        .sdo_o          (sdo),
        .sdo_oe_o       (sdo_oe),
        .cmd_o          (cmd),
        .cfg_o          (cfg),
        .start_o        (start),
        .start_eoc_o    (start_eoc),
        .sck_rise_sel_o (clr)
    );

    sfe_conv #(.RES_W(RES_W), .CONV_CYC(CONV_CYC)) u_conv (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .value_i    (conv_value),
        .res_o      (res),
        .res_next_o (res_next),
        .done_o     (done)
    );

    sfe_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .start_eoc_i (start_eoc),
        .done_i      (done),
        .clr_i       (clr),
        .stat_n_o    (stat_n)
    );
endmodule

// File: tb/adc_serial_frontend_tb_top.sv
`timescale 1ns/1ps
module adc_serial_frontend_tb_top;
    localparam int LAT = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic [11:0] conv_value = '0;
    logic        sdo, sdo_oe, stat_n;
    logic [3:0]  cmd, cfg;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    adc_serial_frontend #(.CONV_CYC(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .conv_value(conv_value), .sdo(sdo), .sdo_oe(sdo_oe),
        .stat_n(stat_n), .cmd(cmd), .cfg(cfg)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // ---------------- behavioural reference model, compared every clock ----------------
    logic q_cs[$]  = '{1'b1, 1'b1, 1'b1};
    logic q_sck[$] = '{1'b0, 1'b0, 1'b0};
    logic q_sdi[$] = '{1'b0, 1'b0, 1'b0};
    logic e_cs_p = 1'b1, e_sck_p = 1'b0;
    int   tick = 0;
    bit   m_oe = 0, m_stat = 1, m_eoc = 0, m_busy = 0, m_act = 0;
    int   m_cmd = 0, m_cfg = 0, m_res = 0, m_samp = 0, m_in = 0, m_falls = 0, m_done_t = 0;
    bit   m_bits[16];

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic ecs, esck, esdi;
            bit csf, csr, rise, fall, done_now;
            tick++;
            q_cs.push_back(cs_n);
            q_sck.push_back(sclk);
            q_sdi.push_back(sdi);
            ecs  = q_cs.pop_front();
            esck = q_sck.pop_front();
            esdi = q_sdi.pop_front();
            csf  = e_cs_p && !ecs;
            csr  = !e_cs_p && ecs;
            rise = !e_sck_p && esck;
            fall = e_sck_p && !esck;
            done_now = m_busy && (tick == m_done_t);
            if (done_now) begin
                m_res  = m_samp;
                m_busy = 0;
            end
            if (csf) begin
                m_oe = 1; m_act = 1; m_falls = 0; m_in = 0;
                for (int i = 0; i < 16; i++)
                    m_bits[i] = (i < 12) ? (m_cfg[1] ? m_res[i] : m_res[11 - i]) : 1'b0;
            end else if (csr) begin
                m_oe = 0; m_act = 0;
            end else if (m_act) begin
                if (rise && m_falls < 8) m_in = ((m_in << 1) | int'(esdi)) & 8'hFF;
                if (fall) begin
                    m_falls++;
                    if (m_falls == 16) begin
                        m_act = 0;
                        m_cmd = (m_in >> 4) & 4'hF;
                        m_cfg = m_in & 4'hF;
                        m_busy = 1;
                        m_done_t = tick + LAT;
                        m_samp = int'(conv_value);
                        m_eoc = m_cfg[0];
                        if (m_eoc) m_stat = 0;
                    end
                end
            end
            if (rise && !ecs && !m_eoc && !done_now) m_stat = 1;
            if (done_now) m_stat = m_eoc ? 1 : 0;
            e_cs_p  = ecs;
            e_sck_p = esck;
            chk("R3 sdo_oe", int'(sdo_oe), int'(m_oe));
            chk("R5 sdo", int'(sdo), (m_oe && m_falls < 16) ? int'(m_bits[m_falls]) : 0);
            chk("R9/R10 stat_n", int'(stat_n), int'(m_stat));
            chk("R4 cmd", int'(cmd), m_cmd);
            chk("R4 cfg", int'(cfg), m_cfg);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic clks(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic bit exp_bit(logic [11:0] r, bit lsb, int i);
        if (i >= 12) return 1'b0;
        return lsb ? r[i] : r[11 - i];
    endfunction

    task automatic shift_bits(logic [7:0] w, int n, output logic [19:0] got);
        got = '0;
        for (int i = 0; i < n; i++) begin
            sdi = (i < 8) ? w[7 - i] : 1'b0;
            got[i] = sdo;
            sclk = 1'b1;
            clks(4);
            sclk = 1'b0;
            clks(4);
        end
    endtask

    task automatic run_frame(logic [7:0] w, int n, output logic [19:0] got);
        cs_n = 1'b0;
        clks(4);
        shift_bits(w, n, got);
        cs_n = 1'b1;
        clks(4);
    endtask

    task automatic chk_read(string req, logic [19:0] got, logic [11:0] r, bit lsb, int n);
        for (int i = 0; i < n; i++) chk(req, int'(got[i]), int'(exp_bit(r, lsb, i)));
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        logic [19:0] got;
        clks(5);
        chk("R1 sdo_oe", int'(sdo_oe), 0);
        chk("R1 stat_n", int'(stat_n), 1);
        chk("R1 cmd", int'(cmd), 0);
        chk("R1 cfg", int'(cfg), 0);
        rst_n = 1'b1;
        clks(5);

        // MSB first, interrupt mode; reads the reset result
        conv_value = 12'hA5C;
        run_frame(8'h50, 16, got);
        chk_read("R3 R5 reset result", got, 12'h000, 1'b0, 16);
        chk("R4 cmd", int'(cmd), 5);
        chk("R4 cfg", int'(cfg), 0);
        clks(LAT + 4);
        chk("R9 int low", int'(stat_n), 0);

        // reads A5C MSB first, programs LSB-first order
        conv_value = 12'h3C1;
        run_frame(8'h32, 16, got);
        chk_read("R5 msb order", got, 12'hA5C, 1'b0, 16);
        chk("R9 int cleared by sclk", int'(stat_n), 1);
        clks(LAT + 4);

        // reads 3C1 LSB first, programs end-of-conversion mode
        conv_value = 12'h800;
        run_frame(8'hA1, 16, got);
        chk_read("R6 lsb order", got, 12'h3C1, 1'b1, 16);
        chk("R10 eoc low while busy", int'(stat_n), 0);
        clks(LAT);
        chk("R10 eoc released", int'(stat_n), 1);
        chk("R4 cmd", int'(cmd), 10);

        // aborted frame
        cs_n = 1'b0;
        clks(4);
        shift_bits(8'hFF, 5, got);
        cs_n = 1'b1;
        clks(LAT + 4);
        chk("R8 cmd kept", int'(cmd), 10);
        chk("R8 cfg kept", int'(cfg), 1);
        chk("R8 no conversion", int'(stat_n), 1);

        // serial activity while deselected
        for (int i = 0; i < 10; i++) begin
            sdi = 1'b1; sclk = 1'b1; clks(4);
            sclk = 1'b0; clks(4);
        end
        chk("R2 oe off", int'(sdo_oe), 0);
        chk("R2 cmd kept", int'(cmd), 10);

        // over-long frame: clocks past 16 ignored
        conv_value = 12'h123;
        run_frame(8'h71, 20, got);
        chk_read("R7 extra clocks", got, 12'h800, 1'b0, 20);
        chk("R7 cmd", int'(cmd), 7);
        clks(LAT + 4);
        chk("R7 single conversion", int'(stat_n), 1);
        run_frame(8'h71, 16, got);
        chk_read("R7 captured value", got, 12'h123, 1'b0, 16);
        clks(LAT + 4);

        // chip-select fall swept across the result store cycle
        for (int o = LAT - 2; o <= LAT + 1; o++) begin
            conv_value = 12'h000;
            run_frame(8'h71, 16, got);
            clks(LAT + 4);
            conv_value = 12'hFFF;
            cs_n = 1'b0;
            clks(4);
            shift_bits(8'h71, 16, got);
            clks(2);
            cs_n = 1'b1;
            clks(o - 6);
            cs_n = 1'b0;
            clks(4);
            chk("R11 first bit at store cycle", int'(sdo), (o >= LAT) ? 1 : 0);
            shift_bits(8'h71, 16, got);
            cs_n = 1'b1;
            clks(LAT + 4);
        end

        finished = 1;
        summary();
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            summary();
        end
    end
endmodule